// File: doc/BRIEF.md
# Framed Recirculating Serial Output Stage

The block holds two parallel-to-serial output lanes for a framed sample interface. One lane carries the compressed code word (up to five bits) and the other carries the linear sample byte (eight bits). Both lanes capture a new parallel word from the codec core when the frame strobe falls. While the strobe is high in the next frame, each lane presents its word on a serial line, most significant bit first. The block does not process the data content.

The first bit appears as soon as the frame strobe rises, with no shift clock needed. Each later bit follows a rising edge of that lane's own shift clock. If more shift edges arrive than the word has bits, the pattern starts again at the most significant bit. The code lane's word length depends on the rate mode. All external strobes and shift clocks are oversampled by one system clock, so every edge takes effect three system clocks after it reaches the pins. A sequencer supplies a path enable for each lane. A lane drives its line, and raises its output-enable, only while the frame strobe is high and its own path enable is asserted.

Top module: `serout_frame`

## Requirements
- R1: Both lanes capture `adWord` and `pcWord` at the falling edge of `frameEn`. Word changes while the frame is high are not seen on the outputs until the next falling edge.
- R2: After `frameEn` rises, `adSdo` shows the code word's most significant bit before any `aClk` edge.
- R3: The code lane moves to the next bit only on rising edges of `aClk` seen while the frame is high. Falling edges of `aClk` leave the output unchanged.
- R4: In rate modes 1, 2 and 3 (`rateSel` = 1, 2, 3), the code word is `adWord[3:0]`, sent bit 3 first. After four rising `aClk` edges, bit 3 is sent again.
- R5: In rate mode 0 (`rateSel` = 0), the code word is `adWord[4:0]`, sent bit 4 first. The fifth rising `aClk` edge brings bit 4 back.
- R6: After `frameEn` rises, `pcSdo` shows bit 7 of the sample byte before any `pClk` edge.
- R7: Each rising `pClk` edge while the frame is high moves the sample lane to the next lower bit. After bit 0, the next rising edge (the eighth) brings bit 7 back.
- R8: When `frameEn` is low, or when a lane's path enable is low, that lane's data line and output-enable are both low.
- R9: Every rising edge of `frameEn` returns both lanes to their most significant bit, even if the previous frame stopped partway through a pattern.
- R10: While `rstN` is low, both output-enables and both data lines are low, and both stored words are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameEn | input | 1 | Frame strobe; falling edge captures words, high level enables shifting |
| aClk | input | 1 | Shift clock for the code lane |
| pClk | input | 1 | Shift clock for the sample lane |
| rateSel | input | 2 | Rate mode: 0 selects the 5-bit code word, 1 to 3 select the 4-bit code word |
| adWord | input | AD_W (5) | Parallel code word from the core |
| pcWord | input | PCM_W (8) | Parallel sample byte from the core |
| adPathEn | input | 1 | Sequencer enable for the code lane |
| pcPathEn | input | 1 | Sequencer enable for the sample lane |
| adSdo | output | 1 | Serial code data |
| adOe | output | 1 | Output-enable for `adSdo` |
| pcSdo | output | 1 | Serial sample data |
| pcOe | output | 1 | Output-enable for `pcSdo` |

## Verification
If a bit pointer is wrong, the wrong bit appears on the serial line three system clocks after the shift-clock edge that caused it, at the latest. A bad wrap point shows up first on the edge right after the expected wrap, so the bench drives more edges than the word length in every mode. If a stored word is wrong, or was captured at the wrong time, the error shows on the most significant bit as soon as the next frame opens, before any shift edge. A faulty enable gate shows the moment a frame opens with one path disabled.

// File: rtl/serout_pkg.sv
package serout_pkg;

  typedef struct packed {
    logic frameOn;
    logic frameRise;
    logic frameFall;
    logic adAdv;
    logic pcAdv;
  } serStrobe_t;

  typedef enum logic [1:0] {
    RATE_40 = 2'd0,
    RATE_32 = 2'd1,
    RATE_24 = 2'd2,
    RATE_16 = 2'd3
  } rate_e;

endpackage

// File: rtl/serout_ctrl.sv
module serout_ctrl
  import serout_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameEn,
  input  logic       aClk,
  input  logic       pClk,
  output serStrobe_t strb
);

  localparam int NIN = 3;
  localparam int IDX_FRAME = 0;
  localparam int IDX_ACLK = 1;
  localparam int IDX_PCLK = 2;

  logic [NIN-1:0] rawIn;
  logic [NIN-1:0] syncQ;
  logic [NIN-1:0] lastQ;
  logic [NIN-1:0] riseVec;
  logic [NIN-1:0] fallVec;

  assign rawIn = {pClk, aClk, frameEn};

  generate
    for (genvar i = 0; i < NIN; i++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], rawIn[i]};
      end
      assign syncQ[i] = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= '0;
    else       lastQ <= syncQ;
  end

  assign riseVec = syncQ & ~lastQ;
  assign fallVec = ~syncQ & lastQ;

  always_comb begin
    strb.frameOn   = lastQ[IDX_FRAME];
    strb.frameRise = riseVec[IDX_FRAME];
    strb.frameFall = fallVec[IDX_FRAME];
    strb.adAdv     = riseVec[IDX_ACLK] & lastQ[IDX_FRAME] & syncQ[IDX_FRAME];
    strb.pcAdv     = riseVec[IDX_PCLK] & lastQ[IDX_FRAME] & syncQ[IDX_FRAME];
  end

endmodule

// File: rtl/serout_lane.sv
module serout_lane #(
  parameter int W  = 8,
  parameter int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic          restart,
  input  logic          adv,
  input  logic          on,
  input  logic          pathEn,
  input  logic [W-1:0]  word,
  input  logic [PW-1:0] lastIdx,
  output logic          sdo,
  output logic          oe,
  output logic [W-1:0]  hold,
  output logic [PW-1:0] ptr
);

  logic [PW-1:0] bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     hold <= '0;
    else if (load) hold <= word;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ptr <= '0;
    else if (restart) ptr <= '0;
    else if (adv)     ptr <= (ptr >= lastIdx) ? '0 : ptr + 1'b1;
  end

  assign bitIdx = lastIdx - ptr;
  assign oe     = on & pathEn;
  assign sdo    = oe & hold[bitIdx];

endmodule

// File: rtl/serout_dp.sv
module serout_dp
  import serout_pkg::*;
#(
  parameter int AD_W  = 5,
  parameter int PCM_W = 8,
  localparam int AD_PW = $clog2(AD_W),
  localparam int PC_PW = $clog2(PCM_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  serStrobe_t       strb,
  input  logic [1:0]       rateSel,
  input  logic [AD_W-1:0]  adWord,
  input  logic [PCM_W-1:0] pcWord,
  input  logic             adPathEn,
  input  logic             pcPathEn,
  output logic             adSdo,
  output logic             adOe,
  output logic             pcSdo,
  output logic             pcOe,
  output logic [AD_W-1:0]  adHold,
  output logic [PCM_W-1:0] pcHold,
  output logic [AD_PW-1:0] adPtr,
  output logic [PC_PW-1:0] pcPtr
);

  localparam logic [AD_PW-1:0] AD_LAST_FULL  = AD_PW'(AD_W - 1);
  localparam logic [AD_PW-1:0] AD_LAST_SHORT = AD_PW'(AD_W - 2);
  localparam logic [PC_PW-1:0] PC_LAST       = PC_PW'(PCM_W - 1);

  logic [AD_PW-1:0] adLast;

  assign adLast = (rateSel == RATE_40) ? AD_LAST_FULL : AD_LAST_SHORT;

  serout_lane #(.W(AD_W), .PW(AD_PW)) u_adLane (
    .clk    (clk),
    .rstN   (rstN),
    .load   (strb.frameFall),
    .restart(strb.frameRise),
    .adv    (strb.adAdv),
    .on     (strb.frameOn),
    .pathEn (adPathEn),
    .word   (adWord),
    .lastIdx(adLast),
    .sdo    (adSdo),
    .oe     (adOe),
    .hold   (adHold),
    .ptr    (adPtr)
  );

  serout_lane #(.W(PCM_W), .PW(PC_PW)) u_pcLane (
    .clk    (clk),
    .rstN   (rstN),
    .load   (strb.frameFall),
    .restart(strb.frameRise),
    .adv    (strb.pcAdv),
    .on     (strb.frameOn),
    .pathEn (pcPathEn),
    .word   (pcWord),
    .lastIdx(PC_LAST),
    .sdo    (pcSdo),
    .oe     (pcOe),
    .hold   (pcHold),
    .ptr    (pcPtr)
  );

endmodule

// File: rtl/serout_frame.sv
module serout_frame
  import serout_pkg::*;
#(
  parameter int AD_W        = 5,
  parameter int PCM_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AD_PW = $clog2(AD_W),
  localparam int PC_PW = $clog2(PCM_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameEn,
  input  logic             aClk,
  input  logic             pClk,
  input  logic [1:0]       rateSel,
  input  logic [AD_W-1:0]  adWord,
  input  logic [PCM_W-1:0] pcWord,
  input  logic             adPathEn,
  input  logic             pcPathEn,
  output logic             adSdo,
  output logic             adOe,
  output logic             pcSdo,
  output logic             pcOe
);

  serStrobe_t       strb;
  logic [AD_W-1:0]  adHold;
  logic [PCM_W-1:0] pcHold;
  logic [AD_PW-1:0] adPtr;
  logic [PC_PW-1:0] pcPtr;

  serout_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .frameEn(frameEn),
    .aClk   (aClk),
    .pClk   (pClk),
    .strb   (strb)
  );

  serout_dp #(.AD_W(AD_W), .PCM_W(PCM_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rateSel (rateSel),
    .adWord  (adWord),
    .pcWord  (pcWord),
    .adPathEn(adPathEn),
    .pcPathEn(pcPathEn),
    .adSdo   (adSdo),
    .adOe    (adOe),
    .pcSdo   (pcSdo),
    .pcOe    (pcOe),
    .adHold  (adHold),
    .pcHold  (pcHold),
    .adPtr   (adPtr),
    .pcPtr   (pcPtr)
  );

endmodule

// File: rtl/serout_frame_chk.sv
module serout_frame_chk
  import serout_pkg::*;
#(
  parameter int AD_W  = 5,
  parameter int PCM_W = 8,
  localparam int AD_PW = $clog2(AD_W),
  localparam int PC_PW = $clog2(PCM_W)
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       rateSel,
  input logic             adPathEn,
  input logic             pcPathEn,
  input logic             adSdo,
  input logic             adOe,
  input logic             pcSdo,
  input logic             pcOe,
  input serStrobe_t       strb,
  input logic [AD_W-1:0]  adHold,
  input logic [PCM_W-1:0] pcHold,
  input logic [AD_PW-1:0] adPtr,
  input logic [PC_PW-1:0] pcPtr
);

  localparam logic [AD_PW-1:0] AD_TOP   = AD_PW'(AD_W - 1);
  localparam logic [AD_PW-1:0] AD_SHORT = AD_PW'(AD_W - 2);
  localparam logic [PC_PW-1:0] PC_TOP   = PC_PW'(PCM_W - 1);

  AST_OE_NEEDS_PATH: assert property (@(posedge clk) disable iff (!rstN)
    (adOe |-> adPathEn) and (pcOe |-> pcPathEn)); // R8
  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!adOe |-> !adSdo) and (!pcOe |-> !pcSdo)); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.frameFall |=> ($stable(adHold) && $stable(pcHold))); // R1
  AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameRise |=> (adPtr == '0 && pcPtr == '0)); // R9
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.adAdv && !strb.frameRise) |=> $stable(adPtr)); // R3
  AST_PC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pcAdv && !strb.frameRise && pcPtr == PC_TOP) |=> pcPtr == '0); // R7
  AST_AD_SHORT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adAdv && !strb.frameRise && rateSel != RATE_40 && adPtr == AD_SHORT)
      |=> adPtr == '0); // R4
  AST_AD_FULL_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adAdv && !strb.frameRise && rateSel == RATE_40 && adPtr == AD_TOP)
      |=> adPtr == '0); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!adOe && !pcOe && !adSdo && !pcSdo)); // R10

endmodule

bind serout_frame serout_frame_chk #(.AD_W(AD_W), .PCM_W(PCM_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .rateSel (rateSel),
  .adPathEn(adPathEn),
  .pcPathEn(pcPathEn),
  .adSdo   (adSdo),
  .adOe    (adOe),
  .pcSdo   (pcSdo),
  .pcOe    (pcOe),
  .strb    (strb),
  .adHold  (adHold),
  .pcHold  (pcHold),
  .adPtr   (adPtr),
  .pcPtr   (pcPtr)
);

// File: tb/serout_frame_bench.sv
`timescale 1ns/1ps
module serout_frame_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameEn = 1'b0;
  logic       aClk = 1'b1;
  logic       pClk = 1'b1;
  logic [1:0] rateSel = 2'd0;
  logic [4:0] adWord = 5'd0;
  logic [7:0] pcWord = 8'd0;
  logic       adPathEn = 1'b0;
  logic       pcPathEn = 1'b0;
  logic       adSdo, adOe, pcSdo, pcOe;

  always #2 clk = ~clk;

  serout_frame u_serout_frame (
    .clk(clk), .rstN(rstN), .frameEn(frameEn), .aClk(aClk), .pClk(pClk),
    .rateSel(rateSel), .adWord(adWord), .pcWord(pcWord),
    .adPathEn(adPathEn), .pcPathEn(pcPathEn),
    .adSdo(adSdo), .adOe(adOe), .pcSdo(pcSdo), .pcOe(pcOe)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [3:0] expQ[$];
  string      tagQ[$];
  event       sampleEv;

  // reference state, derived from the requirements
  logic [4:0] mAd = 5'd0;
  logic [7:0] mPc = 8'd0;
  int  aCnt = 0;
  int  pCnt = 0;
  bit  frameHi = 0;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushCheck(input string tag);
    int  aLen;
    logic aBit, pBit, aO, pO;
    aLen = (rateSel == 2'd0) ? 5 : 4;          // R4 R5 word lengths
    aBit = mAd[aLen - 1 - (aCnt % aLen)];
    pBit = mPc[7 - (pCnt % 8)];
    aO   = frameHi & adPathEn;                  // R8 gating
    pO   = frameHi & pcPathEn;
    expQ.push_back({aO & aBit, aO, pO & pBit, pO});
    tagQ.push_back(tag);
    ->sampleEv;
  endtask

  // monitor: pops one expected item per sample point
  always @(sampleEv) begin
    logic [3:0] e, a;
    string t;
    e = expQ.pop_front();
    t = tagQ.pop_front();
    a = {adSdo, adOe, pcSdo, pcOe};
    compared++;
    if (a !== e) begin
      mismatched++;
      $display("FAIL %s: {adSdo,adOe,pcSdo,pcOe} actual=%b expected=%b at %0t", t, a, e, $time);
    end
  end

  task automatic runFrame(input logic [1:0] r, input int nA, input int nP,
                          input bit aE, input bit pE,
                          input logic [4:0] nextAd, input logic [7:0] nextPc);
    int nMax;
    string aTag;
    rateSel  = r;
    adPathEn = aE;
    pcPathEn = pE;
    aTag = (r == 2'd0) ? "R5" : "R4";
    // junk on the word inputs while the frame is open: must not show (R1)
    adWord = ~nextAd;
    pcWord = ~nextPc;
    waitClk(4);
    frameEn = 1'b1; frameHi = 1; aCnt = 0; pCnt = 0;
    waitClk(6);
    pushCheck("R1 R2 R6 R9 frame open");
    nMax = (nA > nP) ? nA : nP;
    for (int i = 0; i < nMax; i++) begin
      if (i < nA) begin
        aClk = 1'b0; waitClk(6);
        pushCheck("R3 falling aClk");
        aClk = 1'b1; aCnt++; waitClk(6);
        pushCheck(aE ? aTag : "R8 code path off");
      end
      if (i < nP) begin
        pClk = 1'b0; waitClk(6);
        pushCheck("R7 falling pClk");
        pClk = 1'b1; pCnt++; waitClk(6);
        pushCheck(pE ? "R7" : "R8 sample path off");
      end
    end
    adWord = nextAd;
    pcWord = nextPc;
    waitClk(4);
    frameEn = 1'b0; frameHi = 0;
    waitClk(6);
    mAd = nextAd;                               // R1 capture at fall
    mPc = nextPc;
    pushCheck("R8 frame closed");
  endtask

  initial begin
    frameEn = 1'b1; adPathEn = 1'b1; pcPathEn = 1'b1;
    waitClk(5);
    pushCheck("R10 in reset");                  // frameHi is 0: all low
    frameEn = 1'b0;
    waitClk(3);
    rstN = 1'b1;
    waitClk(4);
    // R10: stored words are zero after reset, so the first frame shifts zeros
    runFrame(2'd0, 3, 3, 1, 1, 5'h16, 8'hA5);
    runFrame(2'd0, 12, 18, 1, 1, 5'h1A, 8'h3C);
    runFrame(2'd1, 9, 2, 1, 1, 5'h09, 8'h81);
    runFrame(2'd3, 2, 9, 0, 1, 5'h15, 8'h6E);
    runFrame(2'd2, 6, 3, 1, 0, 5'h13, 8'hD2);
    runFrame(2'd0, 7, 10, 1, 1, 5'h0E, 8'h00);
    runFrame(2'd3, 10, 1, 1, 1, 5'h1F, 8'hFF);
    waitClk(4);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule